// File: doc/BRIEF.md
# Issue Timing and Hazard Interlock Unit

This unit sets the issue timing of an in-order processor that issues at most one instruction per major cycle. A major cycle is a fixed number of clock slots. An instruction is offered as a decoded descriptor. The descriptor gives an operation class, an optional destination register, up to two optional arithmetic source registers, and an optional index register used for effective-address formation. The unit accepts a descriptor only on the last slot of a major cycle, and only when no interlock holds it back.

Each register has a small countdown that holds the number of major cycles until its pending result can be consumed. Single-cycle operations forward their results, so an arithmetic consumer in the next major cycle pays nothing. Multiply and divide hold their consumers back for their full latency. Address generation has no forwarding path. An index register written by the instruction issued just before therefore costs exactly one extra major cycle. The unit reports the major-cycle number of each issue and keeps a running count of stalled major cycles, so scripted instruction sequences can be timed.

Top module: `iss_issue_unit`

## Requirements
- R1: After reset, cycle_count, stall_total, issue_pulse and illegal_pulse are all zero.
- R2: A descriptor is accepted only on the last slot of a major cycle, so successive issue_cycle values strictly increase.
- R3: An operand read of a register written by a single-cycle operation (in_op 0 fixed, 1 floating add) issues in the very next major cycle without a stall.
- R4: An index read (in_ix_use) of the register written by the immediately preceding issued instruction issues no earlier than two major cycles after that producer.
- R5: A consumer of a multiply result (in_op 2) issues no earlier than LAT_MUL (default 2) major cycles after the multiply.
- R6: A consumer of a divide result (in_op 3) issues no earlier than LAT_DIV (default 7) major cycles after the divide.
- R7: An instruction that writes a register with a result still pending waits until that result completes.
- R8: If any used register field is NREGS or above, the descriptor is accepted at the next major-cycle boundary without a stall. illegal_pulse rises for one clock, no issue takes place, and the register state is left unchanged.
- R9: cycle_count increases by one every SLOTS clocks. issue_cycle reports the cycle_count value at which the instruction was accepted, and issue_pulse is high for the one clock that follows.
- R10: stall_total increases by one for each major cycle in which a legal descriptor was offered but held back.
- R11: Instructions with no dependences issue in consecutive major cycles, and register index NREGS-1 is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A descriptor is offered |
| in_op | input | 2 | Operation class: 0 fixed, 1 float add, 2 multiply, 3 divide |
| in_dst_we | input | 1 | Descriptor writes a destination register |
| in_dst | input | RW | Destination register |
| in_sa_use | input | 1 | First arithmetic source is used |
| in_sa | input | RW | First arithmetic source register |
| in_sb_use | input | 1 | Second arithmetic source is used |
| in_sb | input | RW | Second arithmetic source register |
| in_ix_use | input | 1 | Index register used for address formation |
| in_ix | input | RW | Index register |
| in_ready | output | 1 | Descriptor is taken at this clock edge |
| issue_pulse | output | 1 | One-clock strobe after an issue |
| illegal_pulse | output | 1 | One-clock strobe after an illegal descriptor is dropped |
| issue_cycle | output | CW | Major cycle of the latest issue |
| cycle_count | output | CW | Current major-cycle number |
| stall_total | output | CW | Major cycles spent holding back a legal descriptor |

## Verification
The assertions assume that the descriptor stays stable and in_valid stays high until in_ready accepts it. They also assume that the latencies fit the countdown width, and that cycle_count does not wrap during a run. The bench drives each descriptor on a falling edge and holds it until acceptance. It runs with four slots per major cycle, so the counters stay far below their wrap point. Sweeps cover every producer class, every way a consumer can touch the produced register, and zero to two independent fillers in between. A second sweep walks each register field across the legal/illegal boundary.

// File: rtl/iss_pkg.sv
package iss_pkg;
   typedef enum logic [1:0] {
      OP_FIX  = 2'd0,
      OP_FADD = 2'd1,
      OP_FMUL = 2'd2,
      OP_FDIV = 2'd3
   } iss_op_e;

   localparam int NQ = 4; // queried fields: sa, sb, ix, dst
endpackage

// File: rtl/iss_slot_timer.sv
module iss_slot_timer #(
   parameter int SLOTS = 8,
   parameter int CW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          last_slot,
   output logic [CW-1:0] major
);
   localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   generate
      if (SLOTS == 1) begin : g_single
         assign last_slot = 1'b1;
      end else begin : g_multi
         logic [SW-1:0] slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       slot <= '0;
            else if (slot == SW'(SLOTS - 1))  slot <= '0;
            else                              slot <= slot + SW'(1);
         end
         assign last_slot = (slot == SW'(SLOTS - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         major <= '0;
      else if (last_slot) major <= major + CW'(1);
   end

   p_cycle_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      last_slot |=> major == $past(major) + CW'(1));
   p_cycle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !last_slot |=> $stable(major));
endmodule

// File: rtl/iss_scoreboard.sv
module iss_scoreboard #(
   parameter int NREGS = 26,
   parameter int RW    = 5,
   parameter int LW    = 3,
   parameter int NQ    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             wr,
   input  logic [RW-1:0]    wr_idx,
   input  logic [LW-1:0]    wr_lat,
   input  logic [NQ*RW-1:0] q_idx,
   output logic [NQ-1:0]    q_busy
);
   logic [LW-1:0]      cnt [NREGS];
   logic [NREGS-1:0]   busy_v;
   logic [2**RW-1:0]   busy_pad;

   for (genvar r = 0; r < NREGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt[r] <= '0;
         else if (adv && wr && wr_idx == RW'(r))
            cnt[r] <= wr_lat - LW'(1);
         else if (adv && cnt[r] != '0)
            cnt[r] <= cnt[r] - LW'(1);
      end
      assign busy_v[r] = (cnt[r] != '0);

      p_fwd_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && wr && wr_idx == RW'(r) && wr_lat == LW'(1)) |=> !busy_v[r]);
      p_long_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && wr && wr_idx == RW'(r) && wr_lat > LW'(1)) |=> busy_v[r]);
   end

   always_comb begin
      busy_pad = '0;
      busy_pad[NREGS-1:0] = busy_v;
   end

   for (genvar q = 0; q < NQ; q++) begin : g_query
      assign q_busy[q] = busy_pad[q_idx[q*RW +: RW]];
   end
endmodule

// File: rtl/iss_ix_hazard.sv
module iss_ix_hazard #(
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          issue,
   input  logic          we,
   input  logic [RW-1:0] dst,
   input  logic          ix_use,
   input  logic [RW-1:0] ix,
   output logic          hazard
);
   logic          prev_valid;
   logic          prev_we;
   logic [RW-1:0] prev_dst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_valid <= 1'b0;
         prev_we    <= 1'b0;
         prev_dst   <= '0;
      end else if (adv) begin
         prev_valid <= issue;
         if (issue) begin
            prev_we  <= we;
            prev_dst <= dst;
         end
      end
   end

   assign hazard = prev_valid && prev_we && ix_use && (ix == prev_dst);

   p_penalty_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hazard && adv && !issue) |=> !hazard);
endmodule

// File: rtl/iss_issue_unit.sv
module iss_issue_unit #(
   parameter int NREGS   = 26,
   parameter int SLOTS   = 8,
   parameter int LAT_MUL = 2,
   parameter int LAT_DIV = 7,
   parameter int CW      = 16,
   parameter int RW      = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    in_op,
   input  logic          in_dst_we,
   input  logic [RW-1:0] in_dst,
   input  logic          in_sa_use,
   input  logic [RW-1:0] in_sa,
   input  logic          in_sb_use,
   input  logic [RW-1:0] in_sb,
   input  logic          in_ix_use,
   input  logic [RW-1:0] in_ix,
   output logic          in_ready,
   output logic          issue_pulse,
   output logic          illegal_pulse,
   output logic [CW-1:0] issue_cycle,
   output logic [CW-1:0] cycle_count,
   output logic [CW-1:0] stall_total
);
   import iss_pkg::*;
   localparam int LW = $clog2(LAT_DIV + 1);

   initial begin
      assert (NREGS >= 2 && (2 ** RW) >= NREGS) else $error("RW too small for NREGS");
      assert (SLOTS >= 1) else $error("SLOTS must be positive");
      assert (LAT_MUL >= 1 && LAT_DIV >= LAT_MUL) else $error("latency ordering");
   end

   logic          last_slot;
   logic          hz;
   logic          illegal, busy_any, blocked, accept, issue;
   logic [NQ-1:0] q_busy, q_use;
   logic [LW-1:0] lat;
   iss_op_e       op;

   iss_slot_timer #(.SLOTS(SLOTS), .CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .last_slot(last_slot), .major(cycle_count));

   assign q_use   = {in_dst_we, in_ix_use, in_sb_use, in_sa_use};
   assign illegal = (in_dst_we && int'(in_dst) >= NREGS) || (in_ix_use && int'(in_ix) >= NREGS)
                 || (in_sa_use && int'(in_sa) >= NREGS) || (in_sb_use && int'(in_sb) >= NREGS);

   iss_scoreboard #(.NREGS(NREGS), .RW(RW), .LW(LW), .NQ(NQ)) u_sb (
      .clk(clk), .rst_n(rst_n), .adv(last_slot), .wr(issue && in_dst_we),
      .wr_idx(in_dst), .wr_lat(lat), .q_idx({in_dst, in_ix, in_sb, in_sa}),
      .q_busy(q_busy));

   iss_ix_hazard #(.RW(RW)) u_hz (
      .clk(clk), .rst_n(rst_n), .adv(last_slot), .issue(issue), .we(in_dst_we),
      .dst(in_dst), .ix_use(in_ix_use), .ix(in_ix), .hazard(hz));

   assign op = iss_op_e'(in_op);
   always_comb begin
      case (op)
         OP_FMUL: lat = LW'(LAT_MUL);
         OP_FDIV: lat = LW'(LAT_DIV);
         default: lat = LW'(1);
      endcase
   end

   assign busy_any = |(q_busy & q_use);
   assign blocked  = busy_any || hz;
   assign in_ready = last_slot && (illegal || !blocked);
   assign accept   = in_valid && in_ready;
   assign issue    = accept && !illegal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue_pulse   <= 1'b0;
         illegal_pulse <= 1'b0;
         issue_cycle   <= '0;
         stall_total   <= '0;
      end else begin
         issue_pulse   <= issue;
         illegal_pulse <= accept && illegal;
         if (issue) issue_cycle <= cycle_count;
         if (last_slot && in_valid && !illegal && blocked)
            stall_total <= stall_total + CW'(1);
      end
   end

   logic          seen_iss;
   logic [CW-1:0] last_iss;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_iss <= 1'b0;
         last_iss <= '0;
      end else if (issue_pulse) begin
         seen_iss <= 1'b1;
         last_iss <= issue_cycle;
      end
   end

   p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_pulse && seen_iss) |-> issue_cycle > last_iss);
   p_no_dual_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_pulse && illegal_pulse));
   p_stall_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !last_slot |=> $stable(stall_total));
   p_iss_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      issue_pulse |-> issue_cycle == cycle_count - CW'(1));
endmodule

// File: tb/sim_iss_issue_unit.sv
module sim_iss_issue_unit;
   localparam int NREGS = 26;
   localparam int SLOTS = 4;
   localparam int CW    = 16;
   localparam int RW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_op = '0;
   logic          in_dst_we = 1'b0, in_sa_use = 1'b0, in_sb_use = 1'b0, in_ix_use = 1'b0;
   logic [RW-1:0] in_dst = '0, in_sa = '0, in_sb = '0, in_ix = '0;
   logic          in_ready, issue_pulse, illegal_pulse;
   logic [CW-1:0] issue_cycle, cycle_count, stall_total;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int rdy [32];
   int last_iss = -10;
   int last_dst = 0;
   bit last_we  = 1'b0;
   int exp_stall = 0;
   int prev_issue = -1;

   always #4 clk = ~clk;

   iss_issue_unit #(.NREGS(NREGS), .SLOTS(SLOTS), .LAT_MUL(2), .LAT_DIV(7), .CW(CW), .RW(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_dst_we(in_dst_we), .in_dst(in_dst), .in_sa_use(in_sa_use), .in_sa(in_sa),
      .in_sb_use(in_sb_use), .in_sb(in_sb), .in_ix_use(in_ix_use), .in_ix(in_ix),
      .in_ready(in_ready), .issue_pulse(issue_pulse), .illegal_pulse(illegal_pulse),
      .issue_cycle(issue_cycle), .cycle_count(cycle_count), .stall_total(stall_total));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int lat_of(input int op);
      if (op == 2) return 2;
      if (op == 3) return 7;
      return 1;
   endfunction

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic send(input int op, input bit we, input int dst, input bit sau, input int sa,
                       input bit sbu, input int sb, input bit ixu, input int ix, input string tag);
      int pres, e;
      bit bad;
      @(negedge clk);
      in_op = 2'(op); in_dst_we = we; in_dst = RW'(dst);
      in_sa_use = sau; in_sa = RW'(sa); in_sb_use = sbu; in_sb = RW'(sb);
      in_ix_use = ixu; in_ix = RW'(ix); in_valid = 1'b1;
      #1;
      pres = int'(cycle_count);
      while (!in_ready) begin
         @(negedge clk); #1;
      end
      @(posedge clk);
      @(negedge clk); #1;
      in_valid = 1'b0;
      bad = (we && dst >= NREGS) || (sau && sa >= NREGS) || (sbu && sb >= NREGS) || (ixu && ix >= NREGS);
      if (bad) begin
         chk(illegal_pulse == 1'b1 && issue_pulse == 1'b0, "R8 illegal strobe", int'(illegal_pulse), 1);
         chk(int'(cycle_count) == pres + 1, "R8 no stall on illegal", int'(cycle_count), pres + 1);
         chk(int'(stall_total) == exp_stall, "R8 stall unchanged", int'(stall_total), exp_stall);
      end else begin
         e = mx(pres, last_iss + 1);
         if (sau) e = mx(e, rdy[sa]);
         if (sbu) e = mx(e, rdy[sb]);
         if (ixu) e = mx(e, rdy[ix]);
         if (we)  e = mx(e, rdy[dst]);
         if (ixu && last_we && ix == last_dst) e = mx(e, last_iss + 2);
         exp_stall += e - pres;
         chk(issue_pulse == 1'b1 && illegal_pulse == 1'b0, {tag, " issue strobe"}, int'(issue_pulse), 1);
         chk(int'(issue_cycle) == e, {tag, " issue cycle"}, int'(issue_cycle), e);
         chk(int'(stall_total) == exp_stall, "R10 stall total", int'(stall_total), exp_stall);
         chk(int'(issue_cycle) > prev_issue, "R2 order", int'(issue_cycle), prev_issue + 1);
         prev_issue = int'(issue_cycle);
         if (we) rdy[dst] = e + lat_of(op);
         last_iss = e; last_dst = dst; last_we = we;
      end
   endtask

   initial begin
      int c0;
      string tg;
      for (int i = 0; i < 32; i++) rdy[i] = 0;
      repeat (3) @(negedge clk);
      chk(cycle_count == '0 && stall_total == '0, "R1 counters", int'(cycle_count) + int'(stall_total), 0);
      chk(issue_pulse == 1'b0 && illegal_pulse == 1'b0, "R1 strobes", int'(issue_pulse) + int'(illegal_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      c0 = int'(cycle_count);
      repeat (4 * SLOTS) @(negedge clk);
      #1;
      chk(int'(cycle_count) == c0 + 4, "R9 cycle rate", int'(cycle_count), c0 + 4);

      // dependence sweep: producer class x consumer kind x filler gap
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 5; k++) begin
            for (int g = 0; g < 3; g++) begin
               send(p, 1'b1, 5, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R11 producer");
               for (int f = 0; f < g; f++)
                  send(0, 1'b1, 10 + f, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R11 filler");
               if (k == 2) tg = "R4";
               else if (k == 3) tg = "R7";
               else if (k == 4) tg = "R11";
               else if (p < 2) tg = "R3";
               else if (p == 2) tg = "R5";
               else tg = "R6";
               case (k)
                  0: send(1, 1'b1, 20, 1'b1, 5, 1'b0, 0, 1'b0, 0, tg);
                  1: send(0, 1'b1, 21, 1'b0, 0, 1'b1, 5, 1'b0, 0, tg);
                  2: send(0, 1'b1, 22, 1'b0, 0, 1'b0, 0, 1'b1, 5, tg);
                  3: send(1, 1'b1, 5, 1'b0, 0, 1'b0, 0, 1'b0, 0, tg);
                  default: send(1, 1'b1, 23, 1'b1, 24, 1'b0, 0, 1'b0, 0, tg);
               endcase
            end
         end
      end

      // legality sweep over each field near the register-count boundary
      for (int f = 0; f < 4; f++) begin
         for (int idx = 24; idx < 32; idx++) begin
            tg = (idx < NREGS) ? "R11" : "R8";
            case (f)
               0: send(3, 1'b1, 7, 1'b1, idx, 1'b0, 0, 1'b0, 0, tg);
               1: send(3, 1'b1, 7, 1'b0, 0, 1'b1, idx, 1'b0, 0, tg);
               2: send(3, 1'b1, 7, 1'b0, 0, 1'b0, 0, 1'b1, idx, tg);
               default: send(3, 1'b1, idx, 1'b0, 0, 1'b0, 0, 1'b0, 0, tg);
            endcase
            send(0, 1'b1, 8, 1'b1, 7, 1'b0, 0, 1'b0, 0, "R8 follow-up");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int n = 0; n < 150000; n++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule